// File: doc/BRIEF.md
# Two-wire bus condition detector

This block watches the clock and data lines of a two-wire serial bus with a fast system clock, for a slave protocol engine. Each raw line passes through a two-stage synchronizer and a spike filter. A filtered line changes state only after a run of consecutive samples that disagree with its current level. From the two filtered levels the block produces one-cycle pulses for the start condition, the stop condition, both clock edges, and each completed data bit with its value.

The engine owns byte framing, addressing and storage. It asks the block to pull the data line low through a single request input. The block passes that request to the open-drain enable only after the filtered clock has been low for a programmable hold time. While the filtered clock is high, the enable stays frozen. This keeps a transmitting slave from ever moving the data line inside a clock-high phase, where a change would read as a false start or stop.

Both the filter length and the hold delay are derived in system clock cycles from the clock frequency and from nanosecond targets, with each result rounded up.

Top module: `tw_cond_detect`

## Requirements
- R1: After reset, every event output and `sda_pull_o` are 0. The filtered lines reset to the idle-high level.
- R2: A level on either raw line that lasts fewer than FILT_LEN system cycles (FILT_LEN = ceil(SPIKE_NS × CLK_HZ / 1e9), 7 at the defaults) changes no output.
- R3: A fall of filtered SDA while filtered SCL is high, and was high the cycle before, gives a one-cycle `start_o` pulse. The pulse appears FILT_LEN + 3 clock edges after the raw change.
- R4: A rise of filtered SDA while filtered SCL is high, and was high the cycle before, gives a one-cycle `stop_o` pulse.
- R5: A start condition inside a transfer (a repeated start) gives the same `start_o` pulse as the first one. It ends the transfer in progress and opens a new one.
- R6: Between a start and the following stop, each fall of filtered SCL gives a one-cycle `bit_valid_o`. During that pulse, `bit_value_o` equals the SDA level captured at the preceding SCL rise. No bit is reported for a high phase that held a start or stop, and none is reported outside a transfer.
- R7: Each rise and each fall of filtered SCL gives one single-cycle pulse on `scl_rise_o` or `scl_fall_o`, respectively.
- R8: `sda_pull_o` takes the value of `drive_low_req` only once filtered SCL has been low for HOLD_LEN cycles (HOLD_LEN = ceil(HOLD_NS × CLK_HZ / 1e9), 38 at the defaults). While filtered SCL is high, `sda_pull_o` keeps its value. Measured from a raw SCL fall, with the request already set, the enable rises after FILT_LEN + HOLD_LEN + 3 edges.
- R9: `start_o` and `stop_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| drive_low_req | input | 1 | Engine request to pull the data line low |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| bit_valid_o | output | 1 | Completed data bit pulse |
| bit_value_o | output | 1 | Value of the completed bit |
| scl_rise_o | output | 1 | Filtered SCL rising edge pulse |
| scl_fall_o | output | 1 | Filtered SCL falling edge pulse |
| sda_pull_o | output | 1 | Open-drain pull-low enable for the data line |

## Verification
The hardest situation to reach is a spike that is exactly one sample shorter than the filter window. Such a spike must leave every output untouched, while a spike one sample longer must be reported. The bench drives both lines from the falling clock edge and holds glitches for an exact number of cycles, so the run length seen by the filter is known.

The second delicate case is a drive request raised in the middle of a clock-high phase. The enable has to wait through the high phase and then through the full hold window. The bench wires the enable back onto the data line as a wired-AND and counts the clock edges from the raw clock fall to the enable rise.

// File: rtl/tw_cond_pkg.sv
package tw_cond_pkg;

    // Cycles needed to cover ns at clk_hz, rounded up, at least 2
    function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                 input int unsigned ns);
        longint unsigned c;
        c = (clk_hz / 1000 * ns + 999_999) / 1_000_000;
        if (c < 2) c = 2;
        return int'(c);
    endfunction

    typedef struct packed {
        logic start;
        logic stop;
        logic bit_valid;
        logic bit_value;
        logic scl_rise;
        logic scl_fall;
    } tw_evt_t;

endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int unsigned FILT_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_LEN);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [CW-1:0] run;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.level) begin
            st_d.run = '0;
        end else if (st_q.run == CW'(FILT_LEN - 1)) begin
            st_d.level = st_q.s2;
            st_d.run   = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, level: 1'b1, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/tw_event_gen.sv
module tw_event_gen
    import tw_cond_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output tw_evt_t evt_o
);
    typedef struct packed {
        logic    scl_p;
        logic    sda_p;
        logic    busy;
        logic    cap;
        logic    dirty;
        tw_evt_t evt;
    } ev_st_t;

    ev_st_t st_d, st_q;
    logic   rise, fall, high, cond_start, cond_stop;

    always_comb begin
        rise       = scl_f & ~st_q.scl_p;
        fall       = ~scl_f & st_q.scl_p;
        high       = scl_f & st_q.scl_p;
        cond_start = high & st_q.sda_p & ~sda_f;
        cond_stop  = high & ~st_q.sda_p & sda_f;

        st_d       = st_q;
        st_d.scl_p = scl_f;
        st_d.sda_p = sda_f;

        if (cond_start) begin
            st_d.busy = 1'b1;
        end else if (cond_stop) begin
            st_d.busy = 1'b0;
        end

        if (rise) begin
            st_d.cap   = sda_f;
            st_d.dirty = 1'b0;
        end else if (high && (sda_f != st_q.sda_p)) begin
            st_d.dirty = 1'b1;
        end

        st_d.evt.start     = cond_start;
        st_d.evt.stop      = cond_stop;
        st_d.evt.scl_rise  = rise;
        st_d.evt.scl_fall  = fall;
        st_d.evt.bit_valid = fall & st_q.busy & ~st_q.dirty;
        st_d.evt.bit_value = st_q.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0, cap: 1'b0,
                      dirty: 1'b1, evt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
endmodule

// File: rtl/tw_sda_hold.sv
module tw_sda_hold #(
    parameter int unsigned HOLD_LEN = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic req_i,
    output logic pull_o
);
    localparam int unsigned CW = $clog2(HOLD_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] low_cnt;
        logic          pull;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scl_f) begin
            st_d.low_cnt = '0;
        end else if (st_q.low_cnt != CW'(HOLD_LEN)) begin
            st_d.low_cnt = st_q.low_cnt + 1'b1;
        end else begin
            st_d.pull = req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o = st_q.pull;
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
    import tw_cond_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 125_000_000,
    parameter int unsigned     SPIKE_NS = 50,
    parameter int unsigned     HOLD_NS  = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic drive_low_req,
    output logic start_o,
    output logic stop_o,
    output logic bit_valid_o,
    output logic bit_value_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_pull_o
);
    localparam int unsigned FILT_LEN = ns_to_cycles(CLK_HZ, SPIKE_NS);
    localparam int unsigned HOLD_LEN = ns_to_cycles(CLK_HZ, HOLD_NS);
    localparam int unsigned NLINES   = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] flt_lines;
    logic              scl_filt, sda_filt;
    tw_evt_t           evt;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        tw_line_filter #(.FILT_LEN(FILT_LEN)) flt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .level_o (flt_lines[g])
        );
    end

    assign scl_filt = flt_lines[0];
    assign sda_filt = flt_lines[1];

    tw_event_gen evt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (scl_filt),
        .sda_f (sda_filt),
        .evt_o (evt)
    );

    tw_sda_hold #(.HOLD_LEN(HOLD_LEN)) hold_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_f  (scl_filt),
        .req_i  (drive_low_req),
        .pull_o (sda_pull_o)
    );

    assign start_o     = evt.start;
    assign stop_o      = evt.stop;
    assign bit_valid_o = evt.bit_valid;
    assign bit_value_o = evt.bit_value;
    assign scl_rise_o  = evt.scl_rise;
    assign scl_fall_o  = evt.scl_fall;
endmodule

// File: rtl/tw_cond_checker.sv
module tw_cond_checker #(
    parameter int unsigned HOLD_LEN = 38
) (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic start_o,
    input logic stop_o,
    input logic bit_valid_o,
    input logic scl_rise_o,
    input logic scl_fall_o,
    input logic sda_pull_o
);
    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (scl_f) begin
            low_run <= 0;
        end else if (low_run < 32'hFFFF_0000) begin
            low_run <= low_run + 1;
        end
    end

    // R9
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    // R3
    start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> scl_f);

    // R7
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |-> scl_f);

    // R7
    fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |-> !scl_f);

    // R8
    pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> (low_run >= HOLD_LEN));

    // R6
    stop_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !bit_valid_o);
endmodule

bind tw_cond_detect tw_cond_checker #(.HOLD_LEN(HOLD_LEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_f       (scl_filt),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .bit_valid_o (bit_valid_o),
    .scl_rise_o  (scl_rise_o),
    .scl_fall_o  (scl_fall_o),
    .sda_pull_o  (sda_pull_o)
);

// File: tb/tw_cond_detect_tb_top.sv
module tw_cond_detect_tb_top;
    localparam int FLT  = 7;   // ceil(50 ns * 125 MHz)
    localparam int HOLD = 38;  // ceil(300 ns * 125 MHz)
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, req = 1'b0;
    logic sda_bus;
    logic start_o, stop_o, bit_valid_o, bit_value_o, scl_rise_o, scl_fall_o, sda_pull_o;

    int checks = 0, errors = 0;
    int n_start = 0, n_stop = 0, n_bits = 0, n_rise = 0, n_fall = 0;
    logic [31:0] bit_shift = '0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_o;

    tw_cond_detect dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .drive_low_req(req), .start_o(start_o), .stop_o(stop_o),
        .bit_valid_o(bit_valid_o), .bit_value_o(bit_value_o),
        .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .sda_pull_o(sda_pull_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int   q_scl[$], q_sda[$];
    int   m_lvl[2], m_run[2];
    int   m_scl_p, m_sda_p, m_busy, m_cap, m_dirty, m_low, m_pull;
    int   e_start, e_stop, e_bv, e_bval, e_rise, e_fall;
    bit   model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_scl = '{1, 1}; q_sda = '{1, 1};
            m_lvl = '{1, 1}; m_run = '{0, 0};
            m_scl_p = 1; m_sda_p = 1; m_busy = 0; m_cap = 0; m_dirty = 1;
            m_low = 0; m_pull = 0;
            e_start = 0; e_stop = 0; e_bv = 0; e_bval = 0; e_rise = 0; e_fall = 0;
        end else begin
            int s, d, smp[2];
            s = m_lvl[0]; d = m_lvl[1];
            e_rise  = (s == 1 && m_scl_p == 0);
            e_fall  = (s == 0 && m_scl_p == 1);
            e_start = (s == 1 && m_scl_p == 1 && m_sda_p == 1 && d == 0);
            e_stop  = (s == 1 && m_scl_p == 1 && m_sda_p == 0 && d == 1);
            e_bv    = e_fall && m_busy && !m_dirty;
            e_bval  = m_cap;
            if (e_start) m_busy = 1; else if (e_stop) m_busy = 0;
            if (e_rise) begin m_cap = d; m_dirty = 0; end
            else if (s == 1 && m_scl_p == 1 && d != m_sda_p) m_dirty = 1;
            if (s == 1) m_low = 0;
            else if (m_low < HOLD) m_low++;
            else m_pull = req;
            m_scl_p = s; m_sda_p = d;
            smp[0] = q_scl.pop_front(); smp[1] = q_sda.pop_front();
            for (int i = 0; i < 2; i++) begin
                if (smp[i] == m_lvl[i]) m_run[i] = 0;
                else if (m_run[i] == FLT - 1) begin m_lvl[i] = smp[i]; m_run[i] = 0; end
                else m_run[i]++;
            end
            q_scl.push_back(int'(scl_m)); q_sda.push_back(int'(sda_bus));
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R3 start", int'(start_o), e_start);
            check("R4 stop", int'(stop_o), e_stop);
            check("R6 bit_valid", int'(bit_valid_o), e_bv);
            if (e_bv) check("R6 bit_value", int'(bit_value_o), e_bval);
            check("R7 scl_rise", int'(scl_rise_o), e_rise);
            check("R7 scl_fall", int'(scl_fall_o), e_fall);
            check("R8 sda_pull", int'(sda_pull_o), m_pull);
            n_start += start_o; n_stop += stop_o; n_rise += scl_rise_o; n_fall += scl_fall_o;
            if (bit_valid_o) begin n_bits++; bit_shift = {bit_shift[30:0], bit_value_o}; end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_start = 0; n_stop = 0; n_bits = 0; n_rise = 0; n_fall = 0; bit_shift = '0;
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wait_n(HALF);
        sda_m = 0; wait_n(HALF);
        scl_m = 0; wait_n(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_n(HALF);
        scl_m = 1; wait_n(HALF);
        sda_m = 1; wait_n(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_n(HALF);
        scl_m = 1; wait_n(HALF);
        scl_m = 0; wait_n(HALF);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        wait_n(3);
        // R1 reset state
        check("R1 start", int'(start_o), 0);
        check("R1 stop", int'(stop_o), 0);
        check("R1 bit_valid", int'(bit_valid_o), 0);
        check("R1 edges", int'(scl_rise_o | scl_fall_o), 0);
        check("R1 pull", int'(sda_pull_o), 0);
        rst_n = 1; model_on = 1;
        wait_n(HALF);

        // R2 spikes one cycle short of the window
        clear_counts();
        sda_m = 0; wait_n(FLT - 1); sda_m = 1; wait_n(HALF);
        scl_m = 0; wait_n(FLT - 1); scl_m = 1; wait_n(HALF);
        check("R2 sda spike start", n_start, 0);
        check("R2 scl spike fall", n_fall, 0);
        // R2 one cycle longer is accepted; latency of R3
        clear_counts();
        sda_m = 0; k = 0;
        do begin @(posedge clk); k++; @(negedge clk); end while (!start_o && k < 100);
        check("R3 start latency", k, FLT + 3);
        sda_m = 1; wait_n(HALF);
        check("R4 stop after long pulse", n_stop, 1);

        // R6 a byte inside a transfer
        clear_counts();
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
        bus_stop();
        check("R3 start count", n_start, 1);
        check("R4 stop count", n_stop, 1);
        check("R6 bit count", n_bits, 8);
        check("R6 byte value", int'(bit_shift[7:0]), 8'hA5);
        check("R7 rise count", n_rise, 9);
        check("R7 fall count", n_fall, 9);

        // R5 repeated start mid-transfer
        clear_counts();
        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        sda_m = 1; wait_n(HALF); scl_m = 1; wait_n(HALF);
        sda_m = 0; wait_n(HALF); scl_m = 0; wait_n(HALF);
        send_bit(0); send_bit(1);
        bus_stop();
        check("R5 start count", n_start, 2);
        check("R6 bits around restart", n_bits, 5);
        check("R6 restart value", int'(bit_shift[4:0]), 5'b10101);

        // R6 no bits outside a transfer
        clear_counts();
        scl_m = 0; wait_n(HALF);
        send_bit(0); send_bit(1); send_bit(1);
        sda_m = 1; scl_m = 1; wait_n(HALF);
        check("R6 idle bits", n_bits, 0);

        // R8 request raised during SCL high, then hold window after fall
        clear_counts();
        bus_start();
        sda_m = 1; wait_n(HALF);
        scl_m = 1; wait_n(HALF);
        req = 1; wait_n(HALF);
        check("R8 frozen while high", int'(sda_pull_o), 0);
        scl_m = 0; k = 0;
        do begin @(posedge clk); k++; @(negedge clk); end while (!sda_pull_o && k < 500);
        check("R8 hold latency", k, FLT + HOLD + 3);
        wait_n(HALF);
        scl_m = 1; wait_n(HALF);
        req = 0; wait_n(HALF);
        check("R8 held during high", int'(sda_pull_o), 1);
        scl_m = 0; wait_n(FLT + HOLD + 10);
        check("R8 released", int'(sda_pull_o), 0);
        bus_stop();
        check("R9 one stop", n_stop, 1);

        wait_n(10);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule